// File: doc/BRIEF.md
# SIMD Branch Lane-Mask Controller

This block sits beside an eight-lane SIMD datapath whose lanes all receive the same instruction from a single fetch and decode unit. When the shared instruction stream reaches a two-way conditional, each lane evaluates the condition on its own data. The sequencer hands the block the resulting per-lane true/false vector together with a marker saying whether the current instruction opens the conditional, switches to its alternative path, or closes it. The block answers with a per-lane enable mask that gates register write-back. The taken path runs with only the true lanes enabled. The alternative path then runs with only the false lanes of the enclosing mask enabled. Closing the conditional brings back the enclosing mask.

Nested conditionals are kept on a small stack of saved masks. When a path ends up with no lane enabled, the block raises a skip flag so that the sequencer can jump over that path. Two free-running counters record how many instructions were issued and how many lane-cycles did useful work. Their ratio shows how much throughput divergence cost: it falls to one eighth when a single lane is active and stays at full rate when all lanes agree.

Top module: `simd_mask_ctrl`

## Requirements
- R1: After synchronous reset the mask output is all ones, the skip flag and the error flag are low, the stack is empty, and both counters read zero.
- R2: An open marker on a non-full stack saves the current mask and, one cycle later, sets the mask to the current mask ANDed with the condition vector (bit i belongs to lane i).
- R3: A switch marker sets the mask to the saved enclosing mask ANDed with the inverse of the condition vector that was sampled with the matching open marker. The condition input in the switch cycle has no effect.
- R4: A close marker on a non-empty stack restores the saved enclosing mask one cycle later.
- R5: Up to DEPTH conditionals (default 4) nest. Each close marker restores the mask of the level that encloses it.
- R6: The skip flag is high exactly in the cycles in which the mask output is all zeros.
- R7: An open marker while DEPTH levels are saved sets the error flag and leaves the mask and stack unchanged.
- R8: A close or switch marker with an empty stack sets the error flag and leaves the mask unchanged.
- R9: The error flag stays high until reset.
- R10: The issue counter increases by exactly one for every cycle in which the issue input is high, and by zero otherwise.
- R11: In every issue cycle the active-lane counter increases by the number of ones in the mask output of that cycle, which is 8 for a fully coherent cycle and 1 for a single active lane.
- R12: When several markers are high at once, open wins over switch, and switch wins over close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction issues this cycle under mask_o |
| br_open_i | input | 1 | Conditional open marker |
| br_switch_i | input | 1 | Switch to the alternative path |
| br_close_i | input | 1 | Conditional close marker |
| cond_i | input | LANES | Per-lane condition result, bit i is lane i |
| mask_o | output | LANES | Per-lane write-back enable |
| skip_o | output | 1 | Current path has no active lane |
| err_o | output | 1 | Sticky stack overflow or underflow flag |
| issue_cnt_o | output | CNT_W | Issued instruction count |
| active_cnt_o | output | CNT_W | Active lane-cycle count |

## Verification
Every result is registered. The mask, skip and error flags follow a marker on the next rising edge, and both counters include an issue cycle on the edge that ends that cycle. The bench drives one stimulus per cycle one time unit after a rising edge and moves its reference state forward at that moment. It then compares all outputs one time unit after the following edge, so each check covers exactly one registered step. Because the counters sample the mask that is visible during the issue cycle, the reference model adds the population count of its old mask before it applies the marker.

// File: rtl/simd_mask_pkg.sv
package simd_mask_pkg;

  typedef enum logic [1:0] {
    BR_NONE   = 2'd0,
    BR_OPEN   = 2'd1,
    BR_SWITCH = 2'd2,
    BR_CLOSE  = 2'd3
  } br_op_e;

  // open beats switch, switch beats close
  function automatic br_op_e decode_marker(input logic open_m,
                                           input logic switch_m,
                                           input logic close_m);
    if (open_m)        return BR_OPEN;
    else if (switch_m) return BR_SWITCH;
    else if (close_m)  return BR_CLOSE;
    else               return BR_NONE;
  endfunction

endpackage

// File: rtl/lane_popcount.sv
module lane_popcount #(
  parameter int LANES = 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] bits_i,
  output logic [CW-1:0]    count_o
);

  logic [CW-1:0] part [LANES+1];

  assign part[0] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_sum
    assign part[g+1] = part[g] + CW'(bits_i[g]);
  end

  assign count_o = part[LANES];

endmodule

// File: rtl/usage_counters.sv
module usage_counters #(
  parameter int LANES = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic [LANES-1:0] lane_mask_i,
  output logic [CNT_W-1:0] issue_cnt_o,
  output logic [CNT_W-1:0] active_cnt_o
);

  localparam int PW = $clog2(LANES + 1);

  logic [PW-1:0] n_active;

  lane_popcount #(.LANES(LANES)) u_pop (
    .bits_i  (lane_mask_i),
    .count_o (n_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_cnt_o  <= '0;
      active_cnt_o <= '0;
    end else if (issue_i) begin
      issue_cnt_o  <= issue_cnt_o + CNT_W'(1);
      active_cnt_o <= active_cnt_o + CNT_W'(n_active);
    end
  end

endmodule

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int EW    = 16,
  parameter int DEPTH = 4,
  localparam int SPW  = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [EW-1:0] wdata_i,
  output logic [EW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);

  logic [EW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_m1;
  logic [AW-1:0]  wr_idx;
  logic [AW-1:0]  rd_idx;

  assign sp_m1   = sp - SPW'(1);
  assign wr_idx  = AW'(sp);
  assign rd_idx  = AW'(sp_m1);
  assign empty_o = (sp == '0);
  assign full_o  = (sp == SPW'(DEPTH));
  assign top_o   = empty_o ? '0 : mem[rd_idx];

  // storage without reset so it may map onto RAM
  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[wr_idx] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0;
    end else if (push_i && !full_o) begin
      sp <= sp + SPW'(1);
    end else if (pop_i && !empty_o) begin
      sp <= sp_m1;
    end
  end

endmodule

// File: rtl/simd_mask_ctrl.sv
module simd_mask_ctrl
  import simd_mask_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  logic             br_open_i,
  input  logic             br_switch_i,
  input  logic             br_close_i,
  input  logic [LANES-1:0] cond_i,
  output logic [LANES-1:0] mask_o,
  output logic             skip_o,
  output logic             err_o,
  output logic [CNT_W-1:0] issue_cnt_o,
  output logic [CNT_W-1:0] active_cnt_o
);

  localparam int EW = 2 * LANES;

  br_op_e          op;
  logic            stk_push;
  logic            stk_pop;
  logic            stk_empty;
  logic            stk_full;
  logic [EW-1:0]   stk_wdata;
  logic [EW-1:0]   stk_top;
  logic [LANES-1:0] saved_parent;
  logic [LANES-1:0] saved_alt;
  logic [LANES-1:0] mask_d;
  logic            err_d;

  assign op = decode_marker(br_open_i, br_switch_i, br_close_i);

  assign stk_push  = (op == BR_OPEN)  && !stk_full;
  assign stk_pop   = (op == BR_CLOSE) && !stk_empty;
  // save enclosing mask and the alternative-path mask together
  assign stk_wdata = {mask_o, mask_o & ~cond_i};

  assign saved_parent = stk_top[EW-1:LANES];
  assign saved_alt    = stk_top[LANES-1:0];

  mask_stack #(.EW(EW), .DEPTH(DEPTH)) u_stack (
    .clk     (clk),
    .rst     (rst),
    .push_i  (stk_push),
    .pop_i   (stk_pop),
    .wdata_i (stk_wdata),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  always_comb begin
    mask_d = mask_o;
    err_d  = err_o;
    unique case (op)
      BR_OPEN: begin
        if (stk_full) err_d = 1'b1;
        else          mask_d = mask_o & cond_i;
      end
      BR_SWITCH: begin
        if (stk_empty) err_d = 1'b1;
        else           mask_d = saved_alt;
      end
      BR_CLOSE: begin
        if (stk_empty) err_d = 1'b1;
        else           mask_d = saved_parent;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '1;
      skip_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      mask_o <= mask_d;
      skip_o <= (mask_d == '0);
      err_o  <= err_d;
    end
  end

  usage_counters #(.LANES(LANES), .CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue_i),
    .lane_mask_i  (mask_o),
    .issue_cnt_o  (issue_cnt_o),
    .active_cnt_o (active_cnt_o)
  );

endmodule

// File: rtl/simd_mask_ctrl_chk.sv
module simd_mask_ctrl_chk #(
  parameter int LANES = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_i,
  input logic             br_open_i,
  input logic [LANES-1:0] mask_o,
  input logic             skip_o,
  input logic             err_o,
  input logic [CNT_W-1:0] issue_cnt_o,
  input logic [CNT_W-1:0] active_cnt_o,
  input logic             stk_push,
  input logic             stk_full
);

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (mask_o == '1 && !skip_o && !err_o &&
                    issue_cnt_o == '0 && active_cnt_o == '0));

  p_open_narrows_r2: assert property (@(posedge clk) disable iff (rst)
    stk_push |=> ((mask_o & ~$past(mask_o)) == '0));

  p_skip_zero_r6: assert property (@(posedge clk) disable iff (rst)
    skip_o == (mask_o == '0));

  p_overflow_err_r7: assert property (@(posedge clk) disable iff (rst)
    (br_open_i && stk_full) |=> err_o);

  p_overflow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (br_open_i && stk_full) |=> $stable(mask_o));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

  p_issue_inc_r10: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> (issue_cnt_o == $past(issue_cnt_o) + CNT_W'(1)));

  p_issue_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> $stable(issue_cnt_o));

  p_active_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> $stable(active_cnt_o));

  p_active_bound_r11: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> (active_cnt_o - $past(active_cnt_o) <= CNT_W'(LANES)));

endmodule

bind simd_mask_ctrl simd_mask_ctrl_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .issue_i      (issue_i),
  .br_open_i    (br_open_i),
  .mask_o       (mask_o),
  .skip_o       (skip_o),
  .err_o        (err_o),
  .issue_cnt_o  (issue_cnt_o),
  .active_cnt_o (active_cnt_o),
  .stk_push     (stk_push),
  .stk_full     (stk_full)
);

// File: tb/simd_mask_ctrl_bench.sv
`timescale 1ns/1ps
module simd_mask_ctrl_bench;

  localparam int LANES = 8;
  localparam int DEPTH = 4;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             issue_i = 1'b0;
  logic             br_open_i = 1'b0;
  logic             br_switch_i = 1'b0;
  logic             br_close_i = 1'b0;
  logic [LANES-1:0] cond_i = '0;
  logic [LANES-1:0] mask_o;
  logic             skip_o;
  logic             err_o;
  logic [CNT_W-1:0] issue_cnt_o;
  logic [CNT_W-1:0] active_cnt_o;

  always #5 clk = ~clk;

  simd_mask_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_simd_mask_ctrl (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue_i),
    .br_open_i    (br_open_i),
    .br_switch_i  (br_switch_i),
    .br_close_i   (br_close_i),
    .cond_i       (cond_i),
    .mask_o       (mask_o),
    .skip_o       (skip_o),
    .err_o        (err_o),
    .issue_cnt_o  (issue_cnt_o),
    .active_cnt_o (active_cnt_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_par [DEPTH];
  logic [LANES-1:0] m_alt [DEPTH];
  int               m_sp;
  bit               m_err;
  logic [CNT_W-1:0] m_issue;
  logic [CNT_W-1:0] m_active;

  task automatic chk(input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "mask", mask_o, m_mask);
    chk(tag, "skip", skip_o, (m_mask == '0));
    chk(tag, "err", err_o, m_err);
    chk(tag, "issue_cnt", issue_cnt_o, m_issue);
    chk(tag, "active_cnt", active_cnt_o, m_active);
  endtask

  task automatic model_reset();
    m_mask = '1; m_sp = 0; m_err = 1'b0; m_issue = '0; m_active = '0;
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
    compare(tag);
  endtask

  task automatic step(input bit o, input bit s, input bit c,
                      input logic [LANES-1:0] cv, input bit iss,
                      input string tag);
    br_open_i = o; br_switch_i = s; br_close_i = c; cond_i = cv; issue_i = iss;
    if (iss) begin
      m_issue  = m_issue + 1;
      m_active = m_active + CNT_W'($countones(m_mask));
    end
    if (o) begin
      if (m_sp == DEPTH) m_err = 1'b1;
      else begin
        m_par[m_sp] = m_mask;
        m_alt[m_sp] = m_mask & ~cv;
        m_sp++;
        m_mask = m_mask & cv;
      end
    end else if (s) begin
      if (m_sp == 0) m_err = 1'b1;
      else m_mask = m_alt[m_sp-1];
    end else if (c) begin
      if (m_sp == 0) m_err = 1'b1;
      else begin
        m_sp--;
        m_mask = m_par[m_sp];
      end
    end
    @(posedge clk); #1;
    br_open_i = 1'b0; br_switch_i = 1'b0; br_close_i = 1'b0; issue_i = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    @(posedge clk); #1;
    do_reset("R1");

    // coherent issue, R10 and R11
    step(0, 0, 0, 8'h00, 1, "R10");
    step(0, 0, 0, 8'h00, 1, "R11");
    step(0, 0, 0, 8'h00, 0, "R10");

    // simple divergent branch
    step(1, 0, 0, 8'b0000_1011, 1, "R2");
    step(0, 0, 0, 8'h00, 1, "R11");
    step(0, 1, 0, 8'hFF, 0, "R3");   // condition ignored at switch
    step(0, 0, 0, 8'h00, 1, "R11");
    step(0, 0, 1, 8'h00, 0, "R4");

    // all-false path gives skip
    step(1, 0, 0, 8'h00, 0, "R6");
    step(0, 1, 0, 8'h00, 0, "R6");
    step(0, 0, 1, 8'h00, 0, "R4");
    // all-true path: switch path empty
    step(1, 0, 0, 8'hFF, 0, "R2");
    step(0, 1, 0, 8'h5A, 0, "R6");
    step(0, 0, 1, 8'h00, 0, "R4");

    // single lane throughput
    step(1, 0, 0, 8'h01, 0, "R2");
    step(0, 0, 0, 8'h00, 1, "R11");
    step(0, 0, 1, 8'h00, 0, "R4");

    // nesting to full depth, then overflow
    step(1, 0, 0, 8'hF7, 0, "R5");
    step(1, 0, 0, 8'h7E, 0, "R5");
    step(1, 0, 0, 8'h3C, 0, "R5");
    step(0, 1, 0, 8'h00, 0, "R5");
    step(1, 0, 0, 8'h50, 0, "R5");
    step(1, 0, 0, 8'hFF, 0, "R7");
    step(0, 0, 1, 8'h00, 0, "R5");
    step(0, 0, 1, 8'h00, 0, "R5");
    step(0, 0, 1, 8'h00, 0, "R5");
    step(0, 0, 1, 8'h00, 0, "R5");
    step(0, 0, 0, 8'h00, 1, "R9");

    // underflow
    do_reset("R1");
    step(0, 0, 1, 8'h00, 0, "R8");
    step(1, 0, 0, 8'h0F, 0, "R9");
    step(0, 0, 1, 8'h00, 0, "R9");
    do_reset("R1");
    step(0, 1, 0, 8'h33, 0, "R8");

    // marker priority
    do_reset("R1");
    step(1, 1, 1, 8'hC3, 0, "R12");
    step(0, 1, 1, 8'h00, 0, "R12");
    step(0, 0, 1, 8'h00, 0, "R12");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 20);
      if ($urandom % 300 == 0) do_reset("R1");
      else if (r < 5)  step(1, 0, 0, LANES'($urandom), $urandom % 2 == 1, "RND_R2");
      else if (r < 8)  step(0, 1, 0, LANES'($urandom), $urandom % 2 == 1, "RND_R3");
      else if (r < 13) step(0, 0, 1, LANES'($urandom), $urandom % 2 == 1, "RND_R4");
      else if (r < 14) step($urandom % 2 == 1, 1, 1, LANES'($urandom), 1, "RND_R12");
      else             step(0, 0, 0, LANES'($urandom), $urandom % 3 != 0, "RND_R11");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule